// File: doc/BRIEF.md
# One-Hot Instruction Cycle Timer

This block produces the cycle-step signals that drive the control decode of a small 8-bit processor. It keeps a one-hot step register in which exactly one line is active. Each active step covers one full clock cycle, and there is no faster internal clock. Step 0 is the opcode-fetch step, and a fetch marker output is high during it. With ready high, the active position moves forward by one on every clock.

A low ready input holds the register at its current value, so a slow memory can stretch any step. An end-of-instruction input sends the sequence back to the fetch step. This lets the last step of one instruction overlap the fetch of the next. The step that follows a fetch is always step 1, because decode of the new opcode has not finished at that point. The shortest instruction therefore takes two steps. If an instruction reaches the highest step without ending, the register wraps to the fetch step, so it can never become all zero.

Top module: `cycle_step_timer`

## Requirements
- R1: From the first clock edge after reset, exactly one bit of `stepLines` is high on every cycle.
- R2: `rst` is synchronous and overrides every other input. On the clock edge that samples it high, `stepLines` becomes `'b1`, meaning step 0 (fetch) is the only line active.
- R3: If `ready` is low at a clock edge, `stepLines` keeps its value, and `endInstr` has no effect at that edge.
- R4: If `ready` is high and `endInstr` is low at an edge where step k is active (0 < k < NUM_STEPS-1), step k+1 becomes active.
- R5: If `ready` and `endInstr` are both high at an edge where step k is active with k >= 1, step 0 becomes active.
- R6: If `ready` is high at an edge where step NUM_STEPS-1 is active, step 0 becomes active, whatever the value of `endInstr`.
- R7: If `ready` is high at an edge where step 0 is active, step 1 becomes active, and `endInstr` is ignored.
- R8: `fetchMark` is high exactly in the cycles when bit 0 of `stepLines` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one step per cycle |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | High to advance, low to hold the current step |
| endInstr | input | 1 | Current instruction completes at this edge |
| stepLines | output | NUM_STEPS | One-hot step lines; bit 0 is opcode fetch |
| fetchMark | output | 1 | High during the opcode-fetch step |

## Verification
The step register's outputs change one clock after the inputs that cause the change. `fetchMark` is combinational from that register, so it tracks `stepLines` in the same cycle. The bench drives inputs on the falling edge and predicts the step that the following rising edge will select. It compares both outputs on the next falling edge, which places every comparison exactly one register stage after its stimulus. The directed phases cover the fetch-step ignore, an end during a hold, the wrap, and a reset in mid-sequence, and a long random phase follows them.

// File: rtl/cycle_step_pkg.sv
package cycle_step_pkg;

  // Strobes passed from the control module to the step register.
  typedef struct packed {
    logic hold;     // keep the current step
    logic restart;  // load the fetch step
    logic advance;  // move one position forward
  } stepStrobes_t;

endpackage

// File: rtl/cycle_step_ctrl.sv
module cycle_step_ctrl
  import cycle_step_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         ready,
  input  logic         endInstr,
  input  logic         atFetch,
  input  logic         atLast,
  output stepStrobes_t strobes
);

  logic endHonoured;

  // The fetch step always hands over to step 1, so an end request is
  // only acted on from step 1 onward.
  assign endHonoured = endInstr && !atFetch;

  always_comb begin
    strobes         = '0;
    strobes.hold    = !ready;
    strobes.restart = ready && (endHonoured || atLast);
    strobes.advance = ready && !(endHonoured || atLast);
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({strobes.hold, strobes.restart, strobes.advance}) == 1);

endmodule

// File: rtl/cycle_step_reg.sv
module cycle_step_reg
  import cycle_step_pkg::*;
#(
  parameter int NUM_STEPS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  stepStrobes_t         strobes,
  output logic [NUM_STEPS-1:0] stepReg,
  output logic                 atFetch,
  output logic                 atLast
);

  localparam int LAST = NUM_STEPS - 1;

  logic [NUM_STEPS-1:0] nextReg;

  // The fetch bit is loaded on restart and otherwise recirculates when held.
  assign nextReg[0] = strobes.hold ? stepReg[0] : strobes.restart;

  // Every other bit either recirculates or takes the bit below it.
  for (genvar i = 1; i < NUM_STEPS; i++) begin : g_shift
    assign nextReg[i] = strobes.hold ? stepReg[i]
                                     : (strobes.advance & stepReg[i-1]);
  end

  always_ff @(posedge clk) begin
    if (rst) stepReg <= {{(NUM_STEPS-1){1'b0}}, 1'b1};
    else     stepReg <= nextReg;
  end

  assign atFetch = stepReg[0];
  assign atLast  = stepReg[LAST];

  // R1
  one_hot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(stepReg) == 1);

  // R2
  reset_fetch_chk: assert property (@(posedge clk)
    rst |=> stepReg == {{(NUM_STEPS-1){1'b0}}, 1'b1});

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.hold |=> $stable(stepReg));

  // R4
  advance_shift_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.advance |=> stepReg == ($past(stepReg) << 1));

  // R5
  restart_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.restart |=> stepReg[0]);

  // R6
  wrap_fetch_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.hold && atLast) |=> stepReg[0]);

  // R7
  fetch_to_one_chk: assert property (@(posedge clk) disable iff (rst)
    (!strobes.hold && atFetch) |=> stepReg[1]);

endmodule

// File: rtl/cycle_step_timer.sv
module cycle_step_timer
  import cycle_step_pkg::*;
#(
  parameter int NUM_STEPS = 6
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ready,
  input  logic                 endInstr,
  output logic [NUM_STEPS-1:0] stepLines,
  output logic                 fetchMark
);

  stepStrobes_t strobes;
  logic         atFetch;
  logic         atLast;

  cycle_step_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .endInstr (endInstr),
    .atFetch  (atFetch),
    .atLast   (atLast),
    .strobes  (strobes)
  );

  cycle_step_reg #(.NUM_STEPS(NUM_STEPS)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .stepReg (stepLines),
    .atFetch (atFetch),
    .atLast  (atLast)
  );

  assign fetchMark = atFetch;

  // R8
  fetch_mark_chk: assert property (@(posedge clk) disable iff (rst)
    fetchMark == ($countones(stepLines & {{(NUM_STEPS-1){1'b0}}, 1'b1}) == 1));

endmodule

// File: tb/cycle_step_timer_bench.sv
module cycle_step_timer_bench;

  localparam int  NSTEPS  = 6;
  localparam time CLK_PER = 10ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              ready = 1'b0;
  logic              endInstr = 1'b0;
  logic [NSTEPS-1:0] stepLines;
  logic              fetchMark;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int modelStep = 0;
  string modelTag = "R2";

  always #(CLK_PER/2) clk = ~clk;

  cycle_step_timer #(.NUM_STEPS(NSTEPS)) u_cycle_step_timer (
    .clk      (clk),
    .rst      (rst),
    .ready    (ready),
    .endInstr (endInstr),
    .stepLines(stepLines),
    .fetchMark(fetchMark)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
    end
  endtask

  // One cycle: compare against the prediction made on the last falling edge,
  // then apply new inputs and predict the next rising edge.
  task automatic step(input logic r, input logic rd, input logic e);
    @(negedge clk);
    if (cyc > 0) begin
      check(modelTag, int'(stepLines), 1 << modelStep);
      // R1
      check("R1", $countones(stepLines), 1);
      // R8
      check("R8", int'(fetchMark), (modelStep == 0) ? 1 : 0);
    end
    rst = r; ready = rd; endInstr = e;
    if (r) begin
      modelStep = 0; modelTag = "R2";
    end else if (!rd) begin
      modelTag = "R3";
    end else if (modelStep == 0) begin
      modelStep = 1; modelTag = "R7";
    end else if (modelStep == NSTEPS-1) begin
      modelStep = 0; modelTag = "R6";
    end else if (e) begin
      modelStep = 0; modelTag = "R5";
    end else begin
      modelStep = modelStep + 1; modelTag = "R4";
    end
    cyc++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset, with ready and end high to show that reset overrides them (R2)
    step(1, 1, 1);
    step(1, 0, 0);
    // free run through the wrap (R4, R6)
    for (int i = 0; i < 20; i++) step(0, 1, 0);
    // end at fetch is ignored (R7), then a two-step instruction (R5)
    for (int i = 0; i < 6; i++) step(0, 1, 1);
    // hold with end high in every step (R3)
    for (int i = 0; i < 12; i++) step(0, (i % 3) == 2, (i % 3) != 2);
    // three-step instructions
    for (int i = 0; i < 9; i++) step(0, 1, (i % 3) == 2);
    // reset in mid-sequence (R2)
    step(0, 1, 0);
    step(0, 1, 0);
    step(1, 1, 0);
    // random traffic
    for (int i = 0; i < 3000; i++)
      step(($urandom_range(0, 99) == 0), ($urandom_range(0, 3) != 0),
           ($urandom_range(0, 2) == 0));
    step(0, 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule